// File: doc/BRIEF.md
# Transmitter Bind and Channel-Search Controller

This block sits behind a radio receiver and turns two-byte control frames into four 8-bit stick values: aileron, elevator, rudder and throttle. It also decides which transmitter the receiver obeys. After start-up it listens on the channel kept in persistent storage. If no transmitter appears before a timeout, it scans nine channels, first accepting only an unarmed transmitter's bind broadcast and later any valid control frame. When it locks on, it becomes bound. From then on each valid frame restarts a loss-of-signal timer.

When a bound link goes quiet, the block zeroes all stick values and drops the valid-signal flag. It then counts down its retries, and once they run out it raises a radio re-initialise request. Channel changes go to the radio interface as single-cycle request pulses that carry the new channel index. Writes to persistent storage are asked for with a single-cycle strobe, and only when the bound channel differs from the stored one. The reset input `rst_n` is asserted asynchronously and is expected to be released in step with `clk`.

Top module: `rx_bind_ctrl`

## Requirements
- R1: While reset is held, `link_state_o` is 0 (init), sticks and flags are 0 and frames are ignored. On the first clock after release, the block loads the channel from `stored_chan_i`, or 0 if that value is above 8. It emits one `chan_req_o` pulse and enters search-last (`link_state_o`=1), or bound (4) if `wdog_rst_i` is 1.
- R2: A frame with type byte 0x05 loads aileron, 0x06 loads elevator, 0x03 loads rudder and 0x02 loads throttle from the value byte. The new value appears on the output one cycle after the frame is presented with `frame_vld_i`.
- R3: A frame of any other type leaves all four sticks, `sig_valid_o` and `link_state_o` unchanged.
- R4: Type 0x01 with value 0x01 is a bind broadcast. It moves any search state to bound. While bound it is ignored and does not set `sig_valid_o`. Type 0x01 with any other value never binds.
- R5: Every accepted frame sets `sig_valid_o` and reloads the retry counter to 3.
- R6: In search-any (3) a control frame binds. In search-last (1) and search-unarmed (2) a control frame updates its stick but does not change the state.
- R7: The timeout counter restarts on init, on bind and on every accepted frame while bound. `tmo_o` is a one-cycle pulse TMO_CYCLES cycles after the latest restart, and then every TMO_CYCLES cycles. An accepted frame in the same cycle as `tmo_o` cancels the expiry action.
- R8: A timeout in search-last moves to search-unarmed on channel 0, with one `chan_req_o` pulse.
- R9: A timeout in search-unarmed advances the channel by one. A timeout on channel 8 moves to search-any on channel 0. Each timeout gives one `chan_req_o` pulse, and the channel never exceeds 8.
- R10: A timeout in search-any advances the channel, wrapping from 8 to 0, with one `chan_req_o` pulse.
- R11: A timeout while bound zeroes all sticks, clears `sig_valid_o` and decrements the retry counter. When the counter would reach 0, the block gives one `radio_init_o` pulse and reloads the counter to 50.
- R12: On entering bound, `nv_wr_o` pulses for one cycle only if `chan_o` differs from `stored_chan_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_vld_i | input | 1 | A complete two-byte frame is presented this cycle |
| frame_type_i | input | 8 | First frame byte (type) |
| frame_val_i | input | 8 | Second frame byte (value) |
| stored_chan_i | input | 8 | Channel held in persistent storage |
| wdog_rst_i | input | 1 | Last reset came from the watchdog |
| ail_o | output | 8 | Aileron value |
| ele_o | output | 8 | Elevator value |
| rud_o | output | 8 | Rudder value |
| thr_o | output | 8 | Throttle value |
| sig_valid_o | output | 1 | Valid signal flag |
| link_state_o | output | 3 | 0 init, 1 search-last, 2 search-unarmed, 3 search-any, 4 bound |
| chan_o | output | 4 | Current channel index, 0 to 8 |
| chan_req_o | output | 1 | One-cycle request to tune to `chan_o` |
| nv_wr_o | output | 1 | One-cycle request to store `chan_o` persistently |
| radio_init_o | output | 1 | One-cycle request to re-initialise the radio |
| tmo_o | output | 1 | One-cycle timeout expiry pulse |

## Verification
Control frames of each of the four stick types are sent, along with an unknown type and a broadcast type with the wrong value. This separates the per-type stick update from the ignore path and from binding. The same control frame is applied in search-unarmed, in search-any and while bound, which shows that only search-any binds on it. Letting timeouts run through a full unarmed sweep and a wrap in search-any exposes errors in the channel sequence at the channel 8 boundary. Frames spaced shorter than the timeout, and then silence, check the restart timing, the zeroing on loss and the retry count that leads to re-initialisation. Start-ups with an out-of-range stored channel and with a watchdog reset check the storage write decision.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [2:0] {
    LS_INIT    = 3'd0,
    LS_LAST    = 3'd1,
    LS_UNARMED = 3'd2,
    LS_ANY     = 3'd3,
    LS_BOUND   = 3'd4
  } link_state_e;

  localparam logic [7:0] FT_BIND  = 8'h01;
  localparam logic [7:0] BIND_KEY = 8'h01;
  localparam logic [7:0] FT_AIL   = 8'h05;
  localparam logic [7:0] FT_ELE   = 8'h06;
  localparam logic [7:0] FT_RUD   = 8'h03;
  localparam logic [7:0] FT_THR   = 8'h02;

  localparam int NUM_STICKS = 4;
  localparam int SK_AIL = 0;
  localparam int SK_ELE = 1;
  localparam int SK_RUD = 2;
  localparam int SK_THR = 3;

endpackage

// File: rtl/rxb_frame_dec.sv
module rxb_frame_dec
  import rxb_pkg::*;
(
  input  logic [7:0]            type_i,
  input  logic [7:0]            val_i,
  output logic                  bcast_o,
  output logic                  ctrl_o,
  output logic [NUM_STICKS-1:0] sel_o
);

  always_comb begin
    sel_o = '0;
    case (type_i)
      FT_AIL:  sel_o[SK_AIL] = 1'b1;
      FT_ELE:  sel_o[SK_ELE] = 1'b1;
      FT_RUD:  sel_o[SK_RUD] = 1'b1;
      FT_THR:  sel_o[SK_THR] = 1'b1;
      default: sel_o = '0;
    endcase
  end

  assign ctrl_o  = |sel_o;
  assign bcast_o = (type_i == FT_BIND) && (val_i == BIND_KEY);

endmodule

// File: rtl/rxb_timeout.sv
module rxb_timeout #(
  parameter int TMO_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expire_o
);

  localparam int TW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(TMO_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expire_o = (cnt_q == '0);

  always_comb begin
    if (restart_i || expire_o) cnt_d = RELOAD;
    else                       cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rxb_link_fsm.sv
module rxb_link_fsm
  import rxb_pkg::*;
#(
  parameter int NUM_CHAN    = 9,
  parameter int CW          = 4,
  parameter int SW          = 8,
  parameter int LOSS_RELOAD = 3,
  parameter int LOSS_RETRY  = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_vld_i,
  input  logic          bcast_i,
  input  logic          ctrl_i,
  input  logic          expire_i,
  input  logic [SW-1:0] stored_chan_i,
  input  logic          wdog_rst_i,
  output link_state_e   state_o,
  output logic [CW-1:0] chan_o,
  output logic          chan_req_o,
  output logic          nv_wr_o,
  output logic          radio_init_o,
  output logic          sig_valid_o,
  output logic          restart_o,
  output logic          upd_en_o,
  output logic          clr_o
);

  localparam int LW = $clog2(LOSS_RETRY + 1);
  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CHAN - 1);
  localparam logic [SW-1:0] LAST_CH_W = SW'(NUM_CHAN - 1);

  link_state_e   state_q, state_d;
  logic [CW-1:0] chan_q, chan_d;
  logic [LW-1:0] loss_q, loss_d;
  logic          valid_q, valid_d;
  logic          req_q, req_d;
  logic          wr_q, wr_d;
  logic          rinit_q, rinit_d;

  logic          accept;
  logic          bind_now;
  logic [CW-1:0] start_ch;
  logic          bound_expire;

  assign start_ch = (stored_chan_i > LAST_CH_W) ? '0 : stored_chan_i[CW-1:0];
  assign upd_en_o = (state_q != LS_INIT);
  assign accept   = upd_en_o && frame_vld_i &&
                    (ctrl_i || (bcast_i && state_q != LS_BOUND));
  assign bind_now = accept && (state_q != LS_BOUND) &&
                    (bcast_i || state_q == LS_ANY);
  assign bound_expire = expire_i && !accept && (state_q == LS_BOUND);
  assign restart_o = (state_q == LS_INIT) ||
                     (accept && (state_q == LS_BOUND || bind_now));
  assign clr_o = bound_expire;

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    loss_d  = loss_q;
    valid_d = valid_q;
    req_d   = 1'b0;
    wr_d    = 1'b0;
    rinit_d = 1'b0;
    if (state_q == LS_INIT) begin
      chan_d = start_ch;
      req_d  = 1'b1;
      loss_d = LW'(LOSS_RELOAD);
      if (wdog_rst_i) begin
        state_d = LS_BOUND;
        wr_d    = ({{(SW-CW){1'b0}}, start_ch} != stored_chan_i);
      end else begin
        state_d = LS_LAST;
      end
    end else if (accept) begin
      valid_d = 1'b1;
      loss_d  = LW'(LOSS_RELOAD);
      if (bind_now) begin
        state_d = LS_BOUND;
        wr_d    = ({{(SW-CW){1'b0}}, chan_q} != stored_chan_i);
      end
    end else if (expire_i) begin
      case (state_q)
        LS_LAST: begin
          state_d = LS_UNARMED;
          chan_d  = '0;
          req_d   = 1'b1;
        end
        LS_UNARMED: begin
          req_d = 1'b1;
          if (chan_q == LAST_CH) begin
            state_d = LS_ANY;
            chan_d  = '0;
          end else begin
            chan_d = chan_q + CW'(1);
          end
        end
        LS_ANY: begin
          req_d  = 1'b1;
          chan_d = (chan_q == LAST_CH) ? '0 : chan_q + CW'(1);
        end
        LS_BOUND: begin
          valid_d = 1'b0;
          if (loss_q == LW'(1)) begin
            rinit_d = 1'b1;
            loss_d  = LW'(LOSS_RETRY);
          end else begin
            loss_d = loss_q - LW'(1);
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_INIT;
      chan_q  <= '0;
      loss_q  <= '0;
      valid_q <= 1'b0;
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      rinit_q <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      loss_q  <= loss_d;
      valid_q <= valid_d;
      req_q   <= req_d;
      wr_q    <= wr_d;
      rinit_q <= rinit_d;
    end
  end

  assign state_o      = state_q;
  assign chan_o       = chan_q;
  assign chan_req_o   = req_q;
  assign nv_wr_o      = wr_q;
  assign radio_init_o = rinit_q;
  assign sig_valid_o  = valid_q;

endmodule

// File: rtl/rx_bind_ctrl.sv
module rx_bind_ctrl
  import rxb_pkg::*;
#(
  parameter int TMO_CYCLES  = 200000,
  parameter int NUM_CHAN    = 9,
  parameter int LOSS_RELOAD = 3,
  parameter int LOSS_RETRY  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_vld_i,
  input  logic [7:0] frame_type_i,
  input  logic [7:0] frame_val_i,
  input  logic [7:0] stored_chan_i,
  input  logic       wdog_rst_i,
  output logic [7:0] ail_o,
  output logic [7:0] ele_o,
  output logic [7:0] rud_o,
  output logic [7:0] thr_o,
  output logic       sig_valid_o,
  output logic [2:0] link_state_o,
  output logic [3:0] chan_o,
  output logic       chan_req_o,
  output logic       nv_wr_o,
  output logic       radio_init_o,
  output logic       tmo_o
);

  localparam int CW = 4;

  logic                  bcast, ctrl;
  logic [NUM_STICKS-1:0] sel;
  logic                  expire, restart, upd_en, clr;
  link_state_e           state;
  logic [7:0]            stick_q [NUM_STICKS];

  rxb_frame_dec u_dec (
    .type_i  (frame_type_i),
    .val_i   (frame_val_i),
    .bcast_o (bcast),
    .ctrl_o  (ctrl),
    .sel_o   (sel)
  );

  rxb_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .expire_o  (expire)
  );

  rxb_link_fsm #(
    .NUM_CHAN    (NUM_CHAN),
    .CW          (CW),
    .SW          (8),
    .LOSS_RELOAD (LOSS_RELOAD),
    .LOSS_RETRY  (LOSS_RETRY)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_vld_i   (frame_vld_i),
    .bcast_i       (bcast),
    .ctrl_i        (ctrl),
    .expire_i      (expire),
    .stored_chan_i (stored_chan_i),
    .wdog_rst_i    (wdog_rst_i),
    .state_o       (state),
    .chan_o        (chan_o),
    .chan_req_o    (chan_req_o),
    .nv_wr_o       (nv_wr_o),
    .radio_init_o  (radio_init_o),
    .sig_valid_o   (sig_valid_o),
    .restart_o     (restart),
    .upd_en_o      (upd_en),
    .clr_o         (clr)
  );

  for (genvar gi = 0; gi < NUM_STICKS; gi++) begin : g_stick
    logic       ld;
    logic [7:0] nxt;
    assign ld = clr || (upd_en && frame_vld_i && sel[gi]);
    always_comb begin
      if (clr) nxt = '0;
      else     nxt = frame_val_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stick_q[gi] <= '0;
      else if (ld) stick_q[gi] <= nxt;
    end
  end

  assign ail_o        = stick_q[SK_AIL];
  assign ele_o        = stick_q[SK_ELE];
  assign rud_o        = stick_q[SK_RUD];
  assign thr_o        = stick_q[SK_THR];
  assign link_state_o = state;
  assign tmo_o        = expire;

endmodule

// File: rtl/rx_bind_ctrl_chk.sv
module rx_bind_ctrl_chk
  import rxb_pkg::*;
#(
  parameter int NUM_CHAN = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_vld_i,
  input logic [7:0] frame_type_i,
  input logic [7:0] stored_chan_i,
  input logic [7:0] ail_o,
  input logic [7:0] ele_o,
  input logic [7:0] rud_o,
  input logic [7:0] thr_o,
  input logic       sig_valid_o,
  input logic [2:0] link_state_o,
  input logic [3:0] chan_o,
  input logic       nv_wr_o,
  input logic       radio_init_o,
  input logic       tmo_o
);

  logic is_ctrl;
  assign is_ctrl = (frame_type_i == FT_AIL) || (frame_type_i == FT_ELE) ||
                   (frame_type_i == FT_RUD) || (frame_type_i == FT_THR);

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(chan_o) < NUM_CHAN); // R9

  AST_UNARMED_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state_o == LS_UNARMED && tmo_o && !frame_vld_i && 32'(chan_o) == NUM_CHAN - 1)
    |=> (link_state_o == LS_ANY && chan_o == 4'd0)); // R9

  AST_CTRL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && is_ctrl && link_state_o != LS_INIT) |=> sig_valid_o); // R5

  AST_BOUND_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && link_state_o == LS_BOUND && !frame_vld_i)
    |=> (!sig_valid_o && ail_o == 8'd0 && ele_o == 8'd0 && rud_o == 8'd0 && thr_o == 8'd0)); // R11

  AST_REINIT_ONLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    radio_init_o |-> link_state_o == LS_BOUND); // R11

  AST_WRITE_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_o |-> (link_state_o == LS_BOUND && {4'd0, chan_o} != stored_chan_i)); // R12

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> !tmo_o); // R7

  AST_BOUND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    link_state_o == LS_BOUND |=> link_state_o == LS_BOUND); // R4

endmodule

bind rx_bind_ctrl rx_bind_ctrl_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_vld_i   (frame_vld_i),
  .frame_type_i  (frame_type_i),
  .stored_chan_i (stored_chan_i),
  .ail_o         (ail_o),
  .ele_o         (ele_o),
  .rud_o         (rud_o),
  .thr_o         (thr_o),
  .sig_valid_o   (sig_valid_o),
  .link_state_o  (link_state_o),
  .chan_o        (chan_o),
  .nv_wr_o       (nv_wr_o),
  .radio_init_o  (radio_init_o),
  .tmo_o         (tmo_o)
);

// File: tb/rx_bind_ctrl_bench.sv
module rx_bind_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic       clk;
  logic       rst_n;
  logic       frame_vld_i;
  logic [7:0] frame_type_i;
  logic [7:0] frame_val_i;
  logic [7:0] stored_chan_i;
  logic       wdog_rst_i;
  logic [7:0] ail_o, ele_o, rud_o, thr_o;
  logic       sig_valid_o;
  logic [2:0] link_state_o;
  logic [3:0] chan_o;
  logic       chan_req_o, nv_wr_o, radio_init_o, tmo_o;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int wr_cnt = 0;
  int ri_cnt = 0;
  bit done = 0;

  rx_bind_ctrl #(.TMO_CYCLES(TMO)) u_rx_bind_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_vld_i   (frame_vld_i),
    .frame_type_i  (frame_type_i),
    .frame_val_i   (frame_val_i),
    .stored_chan_i (stored_chan_i),
    .wdog_rst_i    (wdog_rst_i),
    .ail_o         (ail_o),
    .ele_o         (ele_o),
    .rud_o         (rud_o),
    .thr_o         (thr_o),
    .sig_valid_o   (sig_valid_o),
    .link_state_o  (link_state_o),
    .chan_o        (chan_o),
    .chan_req_o    (chan_req_o),
    .nv_wr_o       (nv_wr_o),
    .radio_init_o  (radio_init_o),
    .tmo_o         (tmo_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (chan_req_o)   req_cnt++;
      if (nv_wr_o)      wr_cnt++;
      if (radio_init_o) ri_cnt++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] v);
    frame_type_i = t;
    frame_val_i  = v;
    frame_vld_i  = 1'b1;
    step();
    frame_vld_i  = 1'b0;
  endtask

  task automatic wait_tmo(input int n);
    int seen = 0;
    int guard = 0;
    while (seen < n && guard < n * TMO * 2 + 20) begin
      step();
      guard++;
      if (tmo_o) seen++;
    end
    check("R7 timeout pulses seen", seen, n);
    step();
  endtask

  // R1: reset state, then init cycle
  task automatic apply_reset(input logic [7:0] st, input logic wd,
                             input int exp_state, input int exp_ch, input int exp_wr);
    int r0, w0;
    rst_n = 1'b0;
    stored_chan_i = st;
    wdog_rst_i = wd;
    frame_vld_i = 1'b0;
    step();
    step();
    check("R1 reset state", link_state_o, 0);
    check("R1 reset valid", sig_valid_o, 0);
    check("R1 reset sticks", {ail_o, ele_o, rud_o, thr_o}, 0);
    r0 = req_cnt;
    w0 = wr_cnt;
    rst_n = 1'b1;
    step();
    check("R1 init state", link_state_o, exp_state);
    check("R1 init channel", chan_o, exp_ch);
    check("R1 init chan_req", req_cnt - r0, 1);
    check("R12 init write", wr_cnt - w0, exp_wr);
  endtask

  task automatic t_frames_and_bind();
    int w0;
    apply_reset(8'd3, 1'b0, 1, 3, 0);
    send(8'h05, 8'hA5);
    check("R2 aileron", ail_o, 8'hA5);
    check("R5 valid set", sig_valid_o, 1);
    check("R6 last no bind", link_state_o, 1);
    send(8'h06, 8'h3C);
    check("R2 elevator", ele_o, 8'h3C);
    send(8'h03, 8'h81);
    check("R2 rudder", rud_o, 8'h81);
    send(8'h02, 8'h7F);
    check("R2 throttle", thr_o, 8'h7F);
    send(8'h07, 8'h55);
    check("R3 unknown sticks", {ail_o, ele_o, rud_o, thr_o}, 32'hA53C817F);
    check("R3 unknown state", link_state_o, 1);
    send(8'h01, 8'h02);
    check("R4 bad key no bind", link_state_o, 1);
    w0 = wr_cnt;
    send(8'h01, 8'h01);
    check("R4 broadcast binds", link_state_o, 4);
    check("R12 same channel no write", wr_cnt - w0, 0);
  endtask

  task automatic t_bound_loss();
    int seen = 0;
    int n = 0;
    int r0;
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k < 40; k++) begin
        step();
        if (tmo_o) seen++;
      end
      send(8'h02, 8'h10);
    end
    check("R7 keepalive no expiry", seen, 0);
    check("R7 keepalive valid", sig_valid_o, 1);
    check("R2 throttle keepalive", thr_o, 8'h10);
    r0 = ri_cnt;
    while (!tmo_o && n < 1000) begin
      step();
      n++;
    end
    check("R7 expiry distance", n, TMO - 1);
    step();
    check("R11 sticks zeroed", {ail_o, ele_o, rud_o, thr_o}, 0);
    check("R11 valid cleared", sig_valid_o, 0);
    check("R11 still bound", link_state_o, 4);
    send(8'h01, 8'h01);
    check("R4 broadcast ignored when bound", sig_valid_o, 0);
    wait_tmo(1);
    check("R11 no reinit after two", ri_cnt - r0, 0);
    wait_tmo(1);
    check("R11 reinit after three", ri_cnt - r0, 1);
    wait_tmo(1);
    check("R11 retry reloaded", ri_cnt - r0, 1);
  endtask

  task automatic t_search_sweep();
    int r0, w0;
    apply_reset(8'd3, 1'b0, 1, 3, 0);
    r0 = req_cnt;
    wait_tmo(1);
    check("R8 unarmed state", link_state_o, 2);
    check("R8 unarmed channel", chan_o, 0);
    check("R8 chan_req", req_cnt - r0, 1);
    send(8'h05, 8'h11);
    check("R6 unarmed no bind", link_state_o, 2);
    check("R6 unarmed stick", ail_o, 8'h11);
    wait_tmo(8);
    check("R9 unarmed ch8", chan_o, 8);
    check("R9 still unarmed", link_state_o, 2);
    wait_tmo(1);
    check("R9 handoff state", link_state_o, 3);
    check("R9 handoff channel", chan_o, 0);
    wait_tmo(8);
    check("R10 any ch8", chan_o, 8);
    wait_tmo(1);
    check("R10 wrap channel", chan_o, 0);
    check("R10 still any", link_state_o, 3);
    wait_tmo(2);
    check("R10 advance", chan_o, 2);
    check("R9 R10 request count", req_cnt - r0, 21);
    w0 = wr_cnt;
    send(8'h03, 8'h22);
    check("R6 any binds", link_state_o, 4);
    check("R6 rudder", rud_o, 8'h22);
    check("R12 new channel write", wr_cnt - w0, 1);
    check("R12 bound channel", chan_o, 2);
  endtask

  task automatic t_start_cases();
    apply_reset(8'd12, 1'b1, 4, 0, 1);
    apply_reset(8'd5, 1'b1, 4, 5, 0);
    apply_reset(8'd9, 1'b0, 1, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    frame_vld_i = 1'b0;
    frame_type_i = '0;
    frame_val_i = '0;
    stored_chan_i = '0;
    wdog_rst_i = 1'b0;
    step();
    t_frames_and_bind();
    t_bound_loss();
    t_search_sweep();
    t_start_cases();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule